// File: doc/BRIEF.md
# Receive Packet Buffer with Status Queue

This block sits between a receive MAC and a host. The MAC pushes frame bytes one at a time and marks the final byte of each frame together with a 4-bit error code. The bytes land in a circular byte buffer, and every frame owns one entry in a small status queue. The host sees a 16-bit status word for the oldest frame. It pulls that frame's bytes through a read strobe and drops the frame with a discard strobe. Discarding also releases any bytes the host has not read.

The host may look at a frame while it is still arriving. The status word then flags it as incomplete and shows the bytes received so far. Two limits stop reception. One is the number of queued frames. The other is the space left in the byte buffer. Diagnostic outputs report when the write side is inside a frame, when the frame limit is reached, and when the buffer is full. A further output reports a read past the received data. That underrun is a fatal condition and stays set until a reset.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After `rst_n` is released, `host_status` reads 16'h8000 and all flag outputs and `rx_complete` are low.
- R2: For a completed oldest frame, `host_status` is {1'b0, code[3:0], count[10:0]}, where code is the value on `in_code` with the last byte. The code passes through unchanged. Bit 14 set marks an error code.
- R3: While the oldest frame is still arriving, `host_status` is {1'b1, 4'b0000, bytes so far}. `flag_receiving` is high from the first accepted byte until the frame closes.
- R4: Each `host_rd` returns the next byte of the oldest frame on `host_data` one cycle later, in arrival order. A frame may be read while it is still arriving.
- R5: `host_discard` removes the oldest frame and its unread bytes only if that frame is complete. Otherwise it has no effect. A discard and a read in the same cycle perform the discard only.
- R6: With MAX_PKTS (8) frames queued, counting one in progress, `flag_stat_ovr` is high and new frames are refused. The flag clears after a discard.
- R7: `flag_data_ovr` is high while the byte buffer (2048 bytes) is full and clears after one byte is read. A frame that meets a full buffer keeps the bytes already stored and closes with code 4'b1000. Its remaining bytes are ignored.
- R8: A frame whose first byte arrives while the queue or the buffer is full is dropped up to and including its last byte. Nothing is stored for it.
- R9: A `host_rd` with no frame queued, or with all bytes of the oldest frame already read, sets `flag_underrun`. The flag stays set until `rx_reset` or `rst_n`.
- R10: `rx_reset` empties the buffer and the queue, abandons a frame in progress and clears all flags.
- R11: `rx_complete` is high for exactly one cycle after each frame entry closes, including a truncated one.
- R12: A frame that reaches 2047 bytes is closed on its next byte with code 4'b1000 and count 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| rx_reset | input | 1 | Receive reset strobe, synchronous |
| in_valid | input | 1 | A frame byte is present on in_data |
| in_data | input | 8 | Frame byte from the MAC |
| in_last | input | 1 | Qualifies in_valid: this byte ends the frame |
| in_code | input | 4 | Error code for the frame, sampled with the last byte |
| host_rd | input | 1 | Read the next byte of the oldest frame |
| host_discard | input | 1 | Remove the oldest complete frame |
| host_data | output | 8 | Byte returned one cycle after host_rd |
| host_status | output | 16 | Status word of the oldest frame |
| rx_complete | output | 1 | One-cycle pulse after a frame entry closes |
| flag_receiving | output | 1 | A frame is being written into the buffer |
| flag_stat_ovr | output | 1 | Frame queue is at its limit |
| flag_data_ovr | output | 1 | Byte buffer is full |
| flag_underrun | output | 1 | Sticky: a read went past the received data (adapter failure) |

## Verification
The hardest case to reach from the ports is a full byte buffer in the middle of a frame. It needs more than two thousand bytes to be queued and unread, with a frame still arriving when the last free byte is used. The stimulus sends a 1500-byte frame and then a 600-byte frame, so that the second frame hits the limit after 548 bytes. A frame started while the buffer is full then checks that refused frames leave no trace. A single 2049-byte frame covers count saturation, and random batches of short frames with random codes cover queueing and reading in order.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CNT_W  = 11;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_OVERRUN = 4'b1000;

  typedef struct packed {
    logic              done;
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  cnt;
  } rxf_entry_t;

  // Status word seen by the host for the oldest entry.
  function automatic logic [15:0] rxf_status(input logic valid, input rxf_entry_t e);
    if (!valid)  return 16'h8000;
    if (!e.done) return {1'b1, 4'b0000, e.cnt};
    return {1'b0, e.code, e.cnt};
  endfunction
endpackage

// File: rtl/rxf_byte_ram.sv
module rxf_byte_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxf_stat_queue.sv
module rxf_stat_queue
  import rxf_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int QW = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              open,
  input  logic              push,
  input  logic              close,
  input  logic [CODE_W-1:0] close_code,
  input  logic              pop,
  output rxf_entry_t        head,
  output logic              head_valid,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [QW-1:0]     used
);
  rxf_entry_t slots [SLOTS];
  logic [IW-1:0] wr_idx, rd_idx;

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] i);
    return (i == IW'(SLOTS - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (wr_idx == IW'(i)) begin
          if (open) begin
            slots[i].done <= close;
            slots[i].code <= close ? close_code : '0;
            slots[i].cnt  <= CNT_W'(1);
          end else begin
            if (push) slots[i].cnt <= slots[i].cnt + 1'b1;
            if (close) begin
              slots[i].done <= 1'b1;
              slots[i].code <= close_code;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      used   <= '0;
    end else if (clr) begin
      wr_idx <= '0;
      rd_idx <= '0;
      used   <= '0;
    end else begin
      if (close) wr_idx <= next_idx(wr_idx);
      if (pop)   rd_idx <= next_idx(rd_idx);
      case ({open, pop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

  assign head       = slots[rd_idx];
  assign head_valid = (used != '0);
  assign cur_cnt    = slots[wr_idx].cnt;
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int MAX_PKTS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_reset,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic [3:0]  in_code,
  input  logic        host_rd,
  input  logic        host_discard,
  output logic [7:0]  host_data,
  output logic [15:0] host_status,
  output logic        rx_complete,
  output logic        flag_receiving,
  output logic        flag_stat_ovr,
  output logic        flag_data_ovr,
  output logic        flag_underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int QW = $clog2(MAX_PKTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PW-1:0]    wr_ptr, rd_ptr, used_bytes;
  logic [CNT_W-1:0] rd_off;
  logic             receiving, dropping, underrun, cmpl_q;

  rxf_entry_t       head;
  logic             head_valid;
  logic [CNT_W-1:0] cur_cnt;
  logic [QW-1:0]    q_cnt;

  // named internal events
  logic buf_full, q_full, room;
  logic start_ok, start_refused, in_body, trunc;
  logic q_open, q_push, q_close, q_pop, mem_we;
  logic rd_ok, rd_bad;
  logic [CODE_W-1:0] close_code;

  function automatic logic [PW-1:0] skip_rest(input logic [PW-1:0] ptr,
                                               input logic [CNT_W-1:0] cnt,
                                               input logic [CNT_W-1:0] off);
    return ptr + PW'(cnt - off);
  endfunction

  function automatic logic [PW-1:0] fill_level(input logic [PW-1:0] wp, input logic [PW-1:0] rp);
    return wp - rp;
  endfunction

  assign used_bytes = fill_level(wr_ptr, rd_ptr);
  assign buf_full   = (used_bytes == PW'(DEPTH));
  assign q_full     = (q_cnt == QW'(MAX_PKTS));
  assign room       = !buf_full && (cur_cnt != CNT_MAX);

  assign start_ok      = in_valid && !receiving && !dropping && !q_full && !buf_full;
  assign start_refused = in_valid && !receiving && !dropping && (q_full || buf_full);
  assign in_body       = in_valid && receiving;
  assign trunc         = in_body && !room;

  assign q_open     = start_ok;
  assign q_push     = in_body && room;
  assign mem_we     = start_ok || q_push;
  assign q_close    = (start_ok && in_last) || (in_body && (in_last || !room));
  assign close_code = trunc ? CODE_OVERRUN : in_code;

  assign q_pop  = host_discard && head_valid && head.done;
  assign rd_ok  = host_rd && !host_discard && head_valid && (rd_off < head.cnt);
  assign rd_bad = host_rd && !host_discard && !rd_ok;

  rxf_byte_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (in_data),
    .re    (rd_ok),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (host_data)
  );

  rxf_stat_queue #(.SLOTS(MAX_PKTS)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rx_reset),
    .open       (q_open),
    .push       (q_push),
    .close      (q_close),
    .close_code (close_code),
    .pop        (q_pop),
    .head       (head),
    .head_valid (head_valid),
    .cur_cnt    (cur_cnt),
    .used       (q_cnt)
  );

  // write side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      receiving <= 1'b0;
      dropping  <= 1'b0;
      cmpl_q    <= 1'b0;
    end else if (rx_reset) begin
      wr_ptr    <= '0;
      receiving <= 1'b0;
      dropping  <= 1'b0;
      cmpl_q    <= 1'b0;
    end else begin
      cmpl_q <= q_close;
      if (mem_we) wr_ptr <= wr_ptr + 1'b1;
      if (start_ok) receiving <= !in_last;
      else if (in_body && (in_last || !room)) receiving <= 1'b0;
      if (start_refused || trunc) dropping <= !in_last;
      else if (dropping && in_valid && in_last) dropping <= 1'b0;
    end
  end

  // host side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      rd_off   <= '0;
      underrun <= 1'b0;
    end else if (rx_reset) begin
      rd_ptr   <= '0;
      rd_off   <= '0;
      underrun <= 1'b0;
    end else begin
      if (q_pop) begin
        rd_ptr <= skip_rest(rd_ptr, head.cnt, rd_off);
        rd_off <= '0;
      end else if (rd_ok) begin
        rd_ptr <= rd_ptr + 1'b1;
        rd_off <= rd_off + 1'b1;
      end
      if (rd_bad) underrun <= 1'b1;
    end
  end

  assign host_status    = rxf_status(head_valid, head);
  assign rx_complete    = cmpl_q;
  assign flag_receiving = receiving;
  assign flag_stat_ovr  = q_full;
  assign flag_data_ovr  = buf_full;
  assign flag_underrun  = underrun;
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
  parameter int MAX_PKTS = 8,
  parameter int QW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_reset,
  input logic [15:0]   host_status,
  input logic          rx_complete,
  input logic          flag_receiving,
  input logic          flag_stat_ovr,
  input logic          flag_data_ovr,
  input logic          flag_underrun,
  input logic          q_open,
  input logic          q_close,
  input logic          q_pop,
  input logic          mem_we,
  input logic [QW-1:0] q_cnt
);
  AST_INCOMPLETE_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    host_status[15] |-> (host_status[14:11] == 4'b0000)); // R3
  AST_POP_ONLY_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> !host_status[15]); // R5
  AST_NO_OPEN_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_stat_ovr |-> !q_open); // R6
  AST_PKT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QW'(MAX_PKTS)); // R6
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    flag_data_ovr |-> !mem_we); // R7
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_underrun && !rx_reset) |=> flag_underrun); // R9
  AST_RX_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (host_status == 16'h8000 && !flag_receiving && !flag_underrun)); // R10
  AST_COMPLETE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_close && !rx_reset) |=> rx_complete); // R11
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.MAX_PKTS(MAX_PKTS), .QW(QW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_reset       (rx_reset),
  .host_status    (host_status),
  .rx_complete    (rx_complete),
  .flag_receiving (flag_receiving),
  .flag_stat_ovr  (flag_stat_ovr),
  .flag_data_ovr  (flag_data_ovr),
  .flag_underrun  (flag_underrun),
  .q_open         (q_open),
  .q_close        (q_close),
  .q_pop          (q_pop),
  .mem_we         (mem_we),
  .q_cnt          (q_cnt)
);

// File: tb/rx_pkt_fifo_tb_top.sv
module rx_pkt_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, rx_reset;
  logic        in_valid, in_last, host_rd, host_discard;
  logic [7:0]  in_data;
  logic [3:0]  in_code;
  logic [7:0]  host_data;
  logic [15:0] host_status;
  logic        rx_complete, flag_receiving, flag_stat_ovr, flag_data_ovr, flag_underrun;

  int n_chk = 0;
  int n_err = 0;
  logic last_cmpl;

  always #2 clk = ~clk;

  rx_pkt_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_code(in_code),
    .host_rd(host_rd), .host_discard(host_discard),
    .host_data(host_data), .host_status(host_status), .rx_complete(rx_complete),
    .flag_receiving(flag_receiving), .flag_stat_ovr(flag_stat_ovr),
    .flag_data_ovr(flag_data_ovr), .flag_underrun(flag_underrun)
  );

  function automatic logic [7:0] pat(input int id, input int i);
    return 8'((id * 29 + i * 7 + 3) ^ (i >> 3));
  endfunction

  function automatic logic [15:0] exp_done(input logic [3:0] code, input int cnt);
    return (16'(code) << 11) | 16'(cnt);
  endfunction

  function automatic logic [15:0] exp_open(input int cnt);
    return 16'h8000 + 16'(cnt);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input int id, input int len, input logic [3:0] code, input logic close);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = pat(id, i);
      in_last  = close && (i == len - 1);
      in_code  = code;
      tick();
    end
    last_cmpl = rx_complete;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] d);
    host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
    d = host_data;
  endtask

  task automatic discard();
    host_discard = 1'b1;
    tick();
    host_discard = 1'b0;
  endtask

  task automatic pulse_rx_reset();
    rx_reset = 1'b1;
    tick();
    rx_reset = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int lens [4];
    logic [3:0] codes [4];
    int ids [4];
    rst_n = 1'b0; rx_reset = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    in_code = '0; host_rd = 1'b0; host_discard = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 status", host_status, 16'h8000);
    chk("R1 flags", {11'b0, rx_complete, flag_receiving, flag_stat_ovr, flag_data_ovr, flag_underrun}, 16'h0);

    // R3 in-progress frame, R4 read during reception
    send_frame(1, 3, 4'h0, 1'b0);
    chk("R3 receiving", 16'(flag_receiving), 16'h1);
    chk("R3 incomplete status", host_status, exp_open(3));
    read_byte(d); chk("R4 byte0", 16'(d), 16'(pat(1, 0)));
    read_byte(d); chk("R4 byte1", 16'(d), 16'(pat(1, 1)));
    in_valid = 1'b1; in_data = pat(1, 3); in_last = 1'b0; tick();
    in_data = pat(1, 4); in_last = 1'b1; in_code = 4'h0; tick();
    in_valid = 1'b0; in_last = 1'b0;
    chk("R11 pulse high", 16'(rx_complete), 16'h1);
    chk("R2 complete status", host_status, exp_done(4'h0, 5));
    chk("R3 receiving low", 16'(flag_receiving), 16'h0);
    tick();
    chk("R11 pulse one cycle", 16'(rx_complete), 16'h0);
    for (int i = 2; i < 5; i++) begin
      read_byte(d); chk("R4 order", 16'(d), 16'(pat(1, i)));
    end
    discard();
    chk("R5 empty after discard", host_status, 16'h8000);
    discard();
    chk("R5 discard on empty", host_status, 16'h8000);

    // R5 discard ignored on incomplete head
    send_frame(3, 2, 4'h0, 1'b0);
    discard();
    chk("R5 incomplete kept", host_status, exp_open(2));
    in_valid = 1'b1; in_data = pat(3, 2); tick();
    in_data = pat(3, 3); in_last = 1'b1; in_code = 4'b1101; tick();
    in_valid = 1'b0; in_last = 1'b0;
    chk("R2 crc code", host_status, exp_done(4'b1101, 4));
    read_byte(d); chk("R4 frame3 byte0", 16'(d), 16'(pat(3, 0)));
    send_frame(4, 3, 4'b0010, 1'b1);
    discard();
    chk("R2 dribble code", host_status, exp_done(4'b0010, 3));
    read_byte(d); chk("R5 unread bytes dropped", 16'(d), 16'(pat(4, 0)));
    host_rd = 1'b1; host_discard = 1'b1; tick(); host_rd = 1'b0; host_discard = 1'b0;
    chk("R5 discard wins over read", {host_status[15:1], flag_underrun}, 16'h8000);

    // R6 frame limit, R8 refused frame
    for (int k = 0; k < 8; k++) send_frame(10 + k, 2, 4'h0, 1'b1);
    chk("R6 stat ovr set", 16'(flag_stat_ovr), 16'h1);
    send_frame(18, 3, 4'h0, 1'b1);
    chk("R8 refused no receiving", 16'(flag_receiving), 16'h0);
    chk("R6 head unchanged", host_status, exp_done(4'h0, 2));
    discard();
    chk("R6 stat ovr clears", 16'(flag_stat_ovr), 16'h0);
    send_frame(20, 5, 4'h0, 1'b1);
    for (int k = 1; k < 8; k++) begin
      chk("R6 queued frame", host_status, exp_done(4'h0, 2));
      read_byte(d); chk("R6 queued data", 16'(d), 16'(pat(10 + k, 0)));
      discard();
    end
    chk("R8 refused frame absent", host_status, exp_done(4'h0, 5));
    read_byte(d); chk("R6 accepted after clear", 16'(d), 16'(pat(20, 0)));
    discard();

    // R7 buffer full truncation, R8 start while full
    send_frame(30, 1500, 4'h0, 1'b1);
    send_frame(31, 600, 4'h0, 1'b1);
    chk("R7 data ovr set", 16'(flag_data_ovr), 16'h1);
    chk("R7 receiving low after truncation", 16'(flag_receiving), 16'h0);
    send_frame(32, 4, 4'h0, 1'b1);
    read_byte(d); chk("R7 read while full", 16'(d), 16'(pat(30, 0)));
    chk("R7 data ovr clears", 16'(flag_data_ovr), 16'h0);
    discard();
    chk("R7 truncated status", host_status, exp_done(4'b1000, 548));
    read_byte(d); chk("R7 truncated data", 16'(d), 16'(pat(31, 0)));
    discard();
    chk("R8 full-start frame dropped", host_status, 16'h8000);

    // R12 count saturation
    send_frame(40, 2049, 4'h0, 1'b1);
    chk("R12 saturated status", host_status, exp_done(4'b1000, 2047));
    chk("R12 buffer not full", 16'(flag_data_ovr), 16'h0);
    discard();

    // R9 underrun, R10 receive reset
    read_byte(d);
    chk("R9 underrun on empty", 16'(flag_underrun), 16'h1);
    send_frame(50, 2, 4'h0, 1'b1);
    read_byte(d); chk("R9 read still works", 16'(d), 16'(pat(50, 0)));
    chk("R9 sticky", 16'(flag_underrun), 16'h1);
    send_frame(51, 3, 4'h0, 1'b0);
    pulse_rx_reset();
    chk("R10 status empty", host_status, 16'h8000);
    chk("R10 flags clear", {12'b0, flag_receiving, flag_stat_ovr, flag_data_ovr, flag_underrun}, 16'h0);
    send_frame(52, 2, 4'h0, 1'b1);
    read_byte(d); chk("R10 fresh frame data", 16'(d), 16'(pat(52, 0)));
    read_byte(d); read_byte(d);
    chk("R9 read past end", 16'(flag_underrun), 16'h1);
    pulse_rx_reset();
    chk("R10 underrun cleared", 16'(flag_underrun), 16'h0);

    // random batches: R2 R4 R5 R11
    void'($urandom(32'd4242));
    for (int b = 0; b < 40; b++) begin
      int nb;
      nb = 1 + int'($urandom % 4);
      for (int k = 0; k < nb; k++) begin
        ids[k]   = 100 + b * 4 + k;
        lens[k]  = 1 + int'($urandom % 48);
        codes[k] = 4'($urandom);
        send_frame(ids[k], lens[k], codes[k], 1'b1);
        chk("R11 random pulse", 16'(last_cmpl), 16'h1);
      end
      for (int k = 0; k < nb; k++) begin
        int nr;
        chk("R2 random status", host_status, exp_done(codes[k], lens[k]));
        nr = int'($urandom % (lens[k] + 1));
        for (int i = 0; i < nr; i++) begin
          read_byte(d); chk("R4 random data", 16'(d), 16'(pat(ids[k], i)));
        end
        discard();
      end
      chk("R5 random drained", host_status, 16'h8000);
    end
    chk("R9 no spurious underrun", 16'(flag_underrun), 16'h0);
    finish_run();
  end
endmodule